// File: doc/BRIEF.md
# Rotating Priority Resolver

This block chooses which of eight interrupt lines is served next and tracks which lines are currently being served. Lines that are pending and not masked compete by priority. A 3-bit base offset sets which line has the top priority. Priority rank p belongs to line (p + offset) mod 8, and rank 0 is the strongest. The block raises its request output only when the strongest competing line outranks every line already in service. Ranks are compared numerically, so a smaller rank wins.

The block also carries out the end-of-service and rotation commands. A one-cycle command strobe comes with a 3-bit code and a line field. The code decides the action:

| Code | Action |
|------|--------|
| 0 | Turn off rotation on automatic completion |
| 1 | Finish the strongest in-service line |
| 2 | No effect |
| 3 | Finish the named line |
| 4 | Turn on rotation on automatic completion |
| 5 | Finish the strongest in-service line, then rotate past it |
| 6 | Rotate past the named line only |
| 7 | Finish the named line, then rotate past it |

When the CPU acknowledges, the winning line enters service. In automatic completion mode the line is finished in the same step instead, and the offset may rotate past it. A cascaded master can run in nested mode, where its cascade input line (line 2) is left out of the current-priority calculation.

Top module: `rot_prio_resolver`

## Requirements
- R1: `winLine` gives the line of the lowest rank among the registered pending-and-unmasked vector. Line `l` has rank `(l - offset) mod 8`. When no line competes, `winLine` equals the offset.
- R2: `intReq` is high only when the best competing rank is strictly lower than the best rank among in-service lines; an empty vector counts as rank 8. A change on `pendVec` or `maskVec` appears on `intReq` after the next rising clock edge.
- R3: When `nestedMode` and `isMaster` are both high, in-service bit 2 is left out of the current-priority calculation, so line 2 can request again while it is in service.
- R4: `ackStb` taken while `intReq` is high, with `autoEoi` low, sets the in-service bit of `winLine` at the next edge. `ackStb` while `intReq` is low changes nothing.
- R5: With `autoEoi` high, a taken acknowledge leaves `inService` unchanged and pulses that line's `eoiDone` bit. If rotation on automatic completion is enabled, the offset becomes line+1 mod 8.
- R6: Codes 1 and 5 clear the in-service bit of lowest rank; code 5 also sets the offset to that line+1. Both do nothing when `inService` is empty.
- R7: Code 3 clears in-service bit `cmdLine`. Code 7 clears it and sets the offset to `cmdLine`+1. Code 6 sets the offset to `cmdLine`+1 and clears nothing.
- R8: Code 4 enables rotation on automatic completion and code 0 disables it. Code 2 leaves `inService`, the offset and `eoiDone` unchanged.
- R9: Reset clears `inService`, `eoiDone`, the offset, the rotation-enable flag and the registered pending and mask vectors.
- R10: `eoiDone` pulses for one cycle, after the edge that finishes service, with one bit for each finished line. A code-3 or code-7 command pulses the bit of `cmdLine` even when that bit was not in service.
- R11: An acknowledge and a command in the same cycle both take effect. The command sees `inService` as it was before the acknowledge. A set from the acknowledge wins over a clear of the same bit. An offset write from the command wins over one from the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendVec | input | 8 | Pending request lines |
| maskVec | input | 8 | Mask, 1 blocks a line |
| ackStb | input | 1 | CPU acknowledge strobe |
| cmdStb | input | 1 | Command strobe |
| cmdCode | input | 3 | Command code 0..7 |
| cmdLine | input | 3 | Line field for codes 3, 6, 7 |
| autoEoi | input | 1 | Automatic completion on acknowledge |
| nestedMode | input | 1 | Nested mode for a cascaded master |
| isMaster | input | 1 | Instance is the master |
| intReq | output | 1 | Interrupt request |
| winLine | output | 3 | Winning line index |
| inService | output | 8 | In-service vector |
| eoiDone | output | 8 | One-cycle pulse per finished line |

## Verification
An acknowledge and an end-of-service command can land in the same cycle, and both may try to change the in-service vector and the offset. The bench sets this up directly. It first puts line 5 in service, then raises line 1 so that it requests. It then pulses the acknowledge together with code 5. The expected result is that line 1 is in service, `eoiDone` shows line 5, and the offset is 6. A reference model in the bench also runs a long stream of random inputs in which the two strobes often coincide, and it compares every output after each edge.

// File: rtl/rot_prio_pkg.sv
package rot_prio_pkg;

  localparam logic [2:0] CMD_ROT_OFF  = 3'd0;
  localparam logic [2:0] CMD_NS_EOI   = 3'd1;
  localparam logic [2:0] CMD_SP_EOI   = 3'd3;
  localparam logic [2:0] CMD_ROT_ON   = 3'd4;
  localparam logic [2:0] CMD_NS_ROT   = 3'd5;
  localparam logic [2:0] CMD_SET_PRI  = 3'd6;
  localparam logic [2:0] CMD_SP_ROT   = 3'd7;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic setAck;      // put winning line into service
    logic autoClr;     // finish winning line at once
    logic offFromAck;  // offset <- winning line + 1
    logic clrTop;      // finish strongest in-service line
    logic offFromTop;  // offset <- that line + 1
    logic clrLine;     // finish cmdLine
    logic offFromLine; // offset <- cmdLine + 1
  } strobe_t;

endpackage

// File: rtl/rot_prio_find.sv
module rot_prio_find #(
  parameter int LINES = 8,
  localparam int IDXW = $clog2(LINES),
  localparam int PW   = IDXW + 1
) (
  input  logic [LINES-1:0] vec,
  input  logic [IDXW-1:0]  off,
  output logic [PW-1:0]    pri
);
  // lowest rank whose line is set; LINES when empty
  always_comb begin
    pri = PW'(LINES);
    for (int p = LINES - 1; p >= 0; p--) begin
      if (vec[off + IDXW'(p)]) pri = PW'(p);
    end
  end
endmodule

// File: rtl/rot_prio_ctrl.sv
module rot_prio_ctrl
  import rot_prio_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ackStb,
  input  logic       cmdStb,
  input  logic [2:0] cmdCode,
  input  logic       autoEoi,
  input  logic       intReq,
  input  logic       topValid,
  output strobe_t    stb
);
  logic rotAuto;
  logic takeAck;
  logic isNs, isNsRot, isSp, isSpRot, isSetPri;

  always_comb begin
    takeAck  = ackStb & intReq;
    isNs     = cmdStb & (cmdCode == CMD_NS_EOI);
    isNsRot  = cmdStb & (cmdCode == CMD_NS_ROT);
    isSp     = cmdStb & (cmdCode == CMD_SP_EOI);
    isSpRot  = cmdStb & (cmdCode == CMD_SP_ROT);
    isSetPri = cmdStb & (cmdCode == CMD_SET_PRI);

    stb.setAck      = takeAck & ~autoEoi;
    stb.autoClr     = takeAck & autoEoi;
    stb.offFromAck  = takeAck & autoEoi & rotAuto;
    stb.clrTop      = (isNs | isNsRot) & topValid;
    stb.offFromTop  = isNsRot & topValid;
    stb.clrLine     = isSp | isSpRot;
    stb.offFromLine = isSpRot | isSetPri;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rotAuto <= 1'b0;
    else if (cmdStb && cmdCode == CMD_ROT_ON) rotAuto <= 1'b1;
    else if (cmdStb && cmdCode == CMD_ROT_OFF) rotAuto <= 1'b0;
  end
endmodule

// File: rtl/rot_prio_datapath.sv
module rot_prio_datapath
  import rot_prio_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CASCADE_LINE = 2,
  localparam int IDXW = $clog2(LINES),
  localparam int PW   = IDXW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] pendVec,
  input  logic [LINES-1:0] maskVec,
  input  logic [IDXW-1:0]  cmdLine,
  input  logic             nestedMode,
  input  logic             isMaster,
  input  strobe_t          stb,
  output logic             intReq,
  output logic [IDXW-1:0]  winLine,
  output logic             topValid,
  output logic [LINES-1:0] inService,
  output logic [LINES-1:0] eoiDone
);
  logic [LINES-1:0] pendQ, maskQ, isrQ, eoiQ;
  logic [IDXW-1:0]  offQ;
  logic [LINES-1:0] reqVec, curVec;
  logic [PW-1:0]    reqPri, curPri, topPri;
  logic [IDXW-1:0]  topLine;
  logic [LINES-1:0] ackMask, topMask, lineMask, clrMask;
  logic [LINES-1:0] isrNext, eoiNext;
  logic [IDXW-1:0]  offNext;

  always_comb begin
    reqVec = pendQ & ~maskQ;
    curVec = isrQ;
    if (nestedMode && isMaster) curVec[CASCADE_LINE] = 1'b0;
  end

  rot_prio_find #(.LINES(LINES)) u_req (.vec(reqVec), .off(offQ), .pri(reqPri));
  rot_prio_find #(.LINES(LINES)) u_cur (.vec(curVec), .off(offQ), .pri(curPri));
  rot_prio_find #(.LINES(LINES)) u_top (.vec(isrQ),   .off(offQ), .pri(topPri));

  always_comb begin
    intReq   = reqPri < curPri;
    winLine  = reqPri[IDXW-1:0] + offQ;
    topLine  = topPri[IDXW-1:0] + offQ;
    topValid = ~topPri[IDXW];

    ackMask  = LINES'(1) << winLine;
    topMask  = LINES'(1) << topLine;
    lineMask = LINES'(1) << cmdLine;

    clrMask  = (stb.clrTop  ? topMask  : '0)
             | (stb.clrLine ? lineMask : '0);
    isrNext  = (isrQ & ~clrMask) | (stb.setAck ? ackMask : '0);
    eoiNext  = clrMask | (stb.autoClr ? ackMask : '0);

    // command offset writes win over the acknowledge path
    if (stb.offFromLine)     offNext = cmdLine + 1'b1;
    else if (stb.offFromTop) offNext = topLine + 1'b1;
    else if (stb.offFromAck) offNext = winLine + 1'b1;
    else                     offNext = offQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
      isrQ  <= '0;
      eoiQ  <= '0;
      offQ  <= '0;
    end else begin
      pendQ <= pendVec;
      maskQ <= maskVec;
      isrQ  <= isrNext;
      eoiQ  <= eoiNext;
      offQ  <= offNext;
    end
  end

  assign inService = isrQ;
  assign eoiDone   = eoiQ;
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver
  import rot_prio_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CASCADE_LINE = 2,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] pendVec,
  input  logic [LINES-1:0] maskVec,
  input  logic             ackStb,
  input  logic             cmdStb,
  input  logic [2:0]       cmdCode,
  input  logic [IDXW-1:0]  cmdLine,
  input  logic             autoEoi,
  input  logic             nestedMode,
  input  logic             isMaster,
  output logic             intReq,
  output logic [IDXW-1:0]  winLine,
  output logic [LINES-1:0] inService,
  output logic [LINES-1:0] eoiDone
);
  strobe_t stb;
  logic    topValid;

  rot_prio_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ackStb(ackStb), .cmdStb(cmdStb),
    .cmdCode(cmdCode), .autoEoi(autoEoi), .intReq(intReq),
    .topValid(topValid), .stb(stb)
  );

  rot_prio_datapath #(.LINES(LINES), .CASCADE_LINE(CASCADE_LINE)) u_dp (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .maskVec(maskVec),
    .cmdLine(cmdLine), .nestedMode(nestedMode), .isMaster(isMaster),
    .stb(stb), .intReq(intReq), .winLine(winLine), .topValid(topValid),
    .inService(inService), .eoiDone(eoiDone)
  );
endmodule

// File: rtl/rot_prio_resolver_chk.sv
module rot_prio_resolver_chk #(
  parameter int LINES = 8,
  localparam int IDXW = $clog2(LINES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             ackStb,
  input logic             cmdStb,
  input logic [2:0]       cmdCode,
  input logic             autoEoi,
  input logic             nestedMode,
  input logic             isMaster,
  input logic             intReq,
  input logic [IDXW-1:0]  winLine,
  input logic [LINES-1:0] inService,
  input logic [LINES-1:0] eoiDone
);
  p_req_not_in_service_r2: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && !(nestedMode && isMaster)) |-> !inService[winLine]);

  p_ack_sets_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && intReq && !autoEoi) |=> inService[$past(winLine)]);

  p_auto_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb && intReq && autoEoi && !cmdStb) |=> eoiDone == (LINES'(1) << $past(winLine)));

  p_nop_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdStb && cmdCode == 3'd2 && !ackStb) |=> ($stable(inService) && eoiDone == '0));

  p_single_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(ackStb && cmdStb) |=> $onehot0(eoiDone));
endmodule

bind rot_prio_resolver rot_prio_resolver_chk #(.LINES(LINES)) u_chk (
  .clk(clk), .rstN(rstN), .ackStb(ackStb), .cmdStb(cmdStb), .cmdCode(cmdCode),
  .autoEoi(autoEoi), .nestedMode(nestedMode), .isMaster(isMaster),
  .intReq(intReq), .winLine(winLine), .inService(inService), .eoiDone(eoiDone)
);

// File: tb/rot_prio_resolver_test.sv
module rot_prio_resolver_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pendVec = '0, maskVec = '0;
  logic       ackStb = 1'b0, cmdStb = 1'b0;
  logic [2:0] cmdCode = '0, cmdLine = '0;
  logic       autoEoi = 1'b0, nestedMode = 1'b0, isMaster = 1'b0;
  logic       intReq;
  logic [2:0] winLine;
  logic [7:0] inService, eoiDone;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // reference state
  logic [7:0] pendM, maskM, isrM, eoiM;
  int offM;
  bit rotM;

  rot_prio_resolver uut (.*);

  always #5 clk = ~clk;

  function automatic int bestPri(logic [7:0] v, int off);
    for (int p = 0; p < 8; p++) if (v[(p + off) % 8]) return p;
    return 8;
  endfunction

  function automatic bit expReq();
    logic [7:0] cv = isrM;
    if (nestedMode && isMaster) cv[2] = 1'b0;
    return bestPri(pendM & ~maskM, offM) < bestPri(cv, offM);
  endfunction

  function automatic int expWin();
    return (bestPri(pendM & ~maskM, offM) + offM) % 8;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R2 intReq", 32'(intReq), 32'(expReq()));
    chk("R1 winLine", 32'(winLine), 32'(expWin()));
    chk("R4 inService", 32'(inService), 32'(isrM));
    chk("R10 eoiDone", 32'(eoiDone), 32'(eoiM));
  endtask

  task automatic step(logic [7:0] p, logic [7:0] m, bit a, bit c, logic [2:0] code,
                      logic [2:0] ln, bit ae, bit ne, bit ma);
    logic [7:0] setV, clrV, nEoi;
    int nOff, tp, tl, w;
    bit nRot, rq;
    @(negedge clk);
    pendVec = p; maskVec = m; ackStb = a; cmdStb = c; cmdCode = code;
    cmdLine = ln; autoEoi = ae; nestedMode = ne; isMaster = ma;
    #1;
    rq = expReq(); w = expWin();
    setV = '0; clrV = '0; nEoi = '0; nOff = offM; nRot = rotM;
    if (a && rq) begin
      if (ae) begin
        nEoi[w] = 1'b1;
        if (rotM) nOff = (w + 1) % 8;
      end else setV[w] = 1'b1;
    end
    if (c) begin
      case (code)
        3'd0: nRot = 0;
        3'd4: nRot = 1;
        3'd1, 3'd5: begin
          tp = bestPri(isrM, offM);
          if (tp < 8) begin
            tl = (tp + offM) % 8;
            clrV[tl] = 1'b1;
            if (code == 3'd5) nOff = (tl + 1) % 8;
          end
        end
        3'd3: clrV[ln] = 1'b1;
        3'd7: begin clrV[ln] = 1'b1; nOff = (int'(ln) + 1) % 8; end
        3'd6: nOff = (int'(ln) + 1) % 8;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    isrM = (isrM & ~clrV) | setV;
    eoiM = nEoi | clrV;
    offM = nOff; rotM = nRot; pendM = p; maskM = m;
    compareAll();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    pendM = '0; maskM = '0; isrM = '0; eoiM = '0; offM = 0; rotM = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    chk("R9 inService after reset", 32'(inService), 0);
    chk("R9 intReq after reset", 32'(intReq), 0);
    chk("R9 eoiDone after reset", 32'(eoiDone), 0);
    chk("R9 winLine after reset", 32'(winLine), 0);

    // R1: lines 4 and 7 pending, base 0 -> line 4
    step(8'h90, 8'h00, 0, 0, 3'd2, 3'd0, 0, 0, 0);
    chk("R1 win 4", 32'(winLine), 4);
    chk("R2 req raised", 32'(intReq), 1);
    // R4: acknowledge puts 4 into service; 7 may not interrupt
    step(8'h90, 8'h00, 1, 0, 3'd2, 3'd0, 0, 0, 0);
    chk("R4 isr 4", 32'(inService), 8'h10);
    chk("R2 lower line blocked", 32'(intReq), 0);
    // R6: code 5 finishes 4 and rotates base to 5
    step(8'h90, 8'h00, 0, 1, 3'd5, 3'd0, 0, 0, 0);
    chk("R6 isr cleared", 32'(inService), 0);
    chk("R10 done 4", 32'(eoiDone), 8'h10);
    chk("R6 rotated win 7", 32'(winLine), 7);
    // R5: auto completion without rotation
    step(8'h90, 8'h00, 1, 0, 3'd2, 3'd0, 1, 0, 0);
    chk("R5 auto done 7", 32'(eoiDone), 8'h80);
    chk("R5 isr unchanged", 32'(inService), 0);
    chk("R5 no rotate", 32'(winLine), 7);
    // R8: enable rotation, then R5 rotation on auto completion
    step(8'h90, 8'h00, 0, 1, 3'd4, 3'd0, 1, 0, 0);
    step(8'h90, 8'h00, 1, 0, 3'd2, 3'd0, 1, 0, 0);
    chk("R5 auto rotate win 4", 32'(winLine), 4);
    // R3: nested master keeps requesting on line 2
    step(8'h04, 8'h00, 0, 0, 3'd2, 3'd0, 0, 1, 1);
    step(8'h04, 8'h00, 1, 0, 3'd2, 3'd0, 0, 1, 1);
    chk("R3 isr 2", 32'(inService), 8'h04);
    chk("R3 nested req", 32'(intReq), 1);
    step(8'h04, 8'h00, 0, 0, 3'd2, 3'd0, 0, 0, 1);
    chk("R3 plain req off", 32'(intReq), 0);
    // R8: code 2 does nothing
    step(8'h04, 8'h00, 0, 1, 3'd2, 3'd5, 0, 0, 1);
    chk("R8 nop isr", 32'(inService), 8'h04);
    chk("R8 nop done", 32'(eoiDone), 0);
    // R7: specific finish of line 2
    step(8'h04, 8'h00, 0, 1, 3'd3, 3'd2, 0, 0, 1);
    chk("R7 isr clear", 32'(inService), 0);
    chk("R7 done 2", 32'(eoiDone), 8'h04);
    // R7: code 6 rotates only
    step(8'h04, 8'h00, 0, 1, 3'd6, 3'd3, 0, 0, 0);
    chk("R7 code6 isr", 32'(inService), 0);
    chk("R7 code6 done", 32'(eoiDone), 0);
    step(8'h00, 8'h00, 0, 1, 3'd6, 3'd7, 0, 0, 0);
    // R11: ack and code 5 in one cycle
    step(8'h20, 8'h00, 0, 0, 3'd2, 3'd0, 0, 0, 0);
    step(8'h20, 8'h00, 1, 0, 3'd2, 3'd0, 0, 0, 0);
    step(8'h22, 8'h00, 0, 0, 3'd2, 3'd0, 0, 0, 0);
    chk("R11 setup req", 32'(intReq), 1);
    step(8'h22, 8'h00, 1, 1, 3'd5, 3'd0, 0, 0, 0);
    chk("R11 isr", 32'(inService), 8'h02);
    chk("R11 done", 32'(eoiDone), 8'h20);
    chk("R11 win", 32'(winLine), 1);
    chk("R11 req", 32'(intReq), 0);

    // random sweep against the reference
    for (int i = 0; i < 6000; i++) begin
      step(8'($urandom), 8'($urandom & $urandom), ($urandom % 2) == 0,
           ($urandom % 3) == 0, 3'($urandom), 3'($urandom),
           ($urandom % 4) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule